// File: doc/BRIEF.md
# Syndrome round constant shift register

This block keeps the bit-flip constant that a round-key engine combines with its keys. A 49-bit seed is loaded. The seed holds seven 7-bit fields, and in normal use each field is one of the single-error syndromes of a 7-bit Hamming codeword (a one-hot value). On load, the block spreads the seed over a 126-bit field of eighteen 7-bit blocks. It then presents the result as a 128-bit constant whose two top bits are held at zero.

Between rounds, the key engine can ask for a number of block rotations, from 0 to 17. The block carries out one 7-bit circular rotation of the 126-bit field per clock, so each block always holds exactly one syndrome. It drops `ready_o` while further rotations are still pending. How the constant is applied to keys is left to the surrounding logic.

Top module: `syn_rc_rotator`

## Requirements
- R1: After reset, `const_o` is all zeros and `ready_o` is 1.
- R2: On a cycle with `load_i` high, the next `const_o` holds in block k (bits 7k+6..7k, k = 0..17) the seed field number k mod 7, where seed field j is `seed_i` bits 7j+6..7j; any seed value is copied unchanged.
- R3: `const_o` bits 127 and 126 are zero in every cycle.
- R4: One rotation step moves block k to block k+1 for k = 0..16 and moves block 17 to block 0, within bits 125..0, and preserves the number of set bits.
- R5: A `shift_i` request with `ready_o` high and count n = `steps_i` (5 bits) in 1..17 performs n rotations on n consecutive clock edges, beginning at the edge that accepts the request; a count above 17 is treated as 17.
- R6: `ready_o` is 0 exactly while rotations of an accepted request remain to be done (n-1 cycles), and a `shift_i` request made while `ready_o` is 0 has no effect on `const_o`.
- R7: `load_i` has priority over `shift_i` and over a sequence in progress: it cancels the pending rotations, and `ready_o` is 1 in the following cycle.
- R8: A `shift_i` request with count 0 leaves `const_o` unchanged and `ready_o` at 1.
- R9: Eighteen rotations after a load return `const_o` to the loaded pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Load and expand the seed |
| seed_i | input | 49 | Seven 7-bit syndrome fields |
| shift_i | input | 1 | Request a rotation sequence |
| steps_i | input | 5 | Number of 7-bit rotations requested |
| const_o | output | 128 | Round constant, bits 127..126 zero |
| ready_o | output | 1 | High when no rotation is pending |

## Verification
The bench targets the wrap of block 17 into block 0, which a design with a wrong rotate slice would get wrong by smearing bits into the two top bits or by losing a syndrome. It checks an over-range count (31 must act as 17) and a count of 0. A design that does not saturate would run too long, and a design that mishandles zero would rotate once or hang with `ready_o` low. It also sends a shift request while a sequence is running and a load in the middle of a sequence. A design without the right priority would extend the run, ignore the new seed, or leave `ready_o` low. The full 18-step period and a non-one-hot seed expose expansion placement errors.

// File: rtl/syn_rc_pkg.sv
package syn_rc_pkg;
    // Default geometry of the round constant
    localparam int SYN_W_DEF   = 7;   // width of one syndrome block
    localparam int SYN_CNT_DEF = 7;   // syndromes in the seed
    localparam int BLK_CNT_DEF = 18;  // blocks in the expanded field
    localparam int PAD_W_DEF   = 2;   // zero bits above the field
endpackage

// File: rtl/syn_seed_expand.sv
module syn_seed_expand #(
    parameter int BLK_W   = 7,
    parameter int NUM_SYN = 7,
    parameter int NUM_BLK = 18
) (
    input  logic [BLK_W*NUM_SYN-1:0] seed_i,
    output logic [BLK_W*NUM_BLK-1:0] pat_o
);
    // block k copies seed field (k mod NUM_SYN)
    for (genvar k = 0; k < NUM_BLK; k++) begin : g_blk
        localparam int SRC = k % NUM_SYN;
        assign pat_o[k*BLK_W +: BLK_W] = seed_i[SRC*BLK_W +: BLK_W];
    end
endmodule

// File: rtl/syn_block_rotate.sv
module syn_block_rotate #(
    parameter int BLK_W   = 7,
    parameter int NUM_BLK = 18
) (
    input  logic [BLK_W*NUM_BLK-1:0] pat_i,
    output logic [BLK_W*NUM_BLK-1:0] pat_o
);
    localparam int FIELD_W = BLK_W * NUM_BLK;

    // one block upward, top block wraps to block 0
    always_comb begin
        pat_o = {pat_i[FIELD_W-BLK_W-1:0], pat_i[FIELD_W-1:FIELD_W-BLK_W]};
    end
endmodule

// File: rtl/syn_rc_rotator.sv
module syn_rc_rotator
    import syn_rc_pkg::*;
#(
    parameter int BLK_W   = SYN_W_DEF,
    parameter int NUM_SYN = SYN_CNT_DEF,
    parameter int NUM_BLK = BLK_CNT_DEF,
    parameter int PAD_W   = PAD_W_DEF
) (
    input  logic                               clk_i,
    input  logic                               rst_ni,
    input  logic                               load_i,
    input  logic [BLK_W*NUM_SYN-1:0]           seed_i,
    input  logic                               shift_i,
    input  logic [$clog2(NUM_BLK)-1:0]         steps_i,
    output logic [BLK_W*NUM_BLK+PAD_W-1:0]     const_o,
    output logic                               ready_o
);
    localparam int FIELD_W  = BLK_W * NUM_BLK;
    localparam int OUT_W    = FIELD_W + PAD_W;
    localparam int CNT_W    = $clog2(NUM_BLK);
    localparam int MAX_STEP = NUM_BLK - 1;

    typedef struct packed {
        logic [FIELD_W-1:0] pat;
        logic [CNT_W-1:0]   left;
    } rc_state_t;

    rc_state_t          st_d, st_q;
    logic [FIELD_W-1:0] seed_pat;
    logic [FIELD_W-1:0] rot_pat;
    logic [CNT_W-1:0]   req_steps;

    syn_seed_expand #(
        .BLK_W   (BLK_W),
        .NUM_SYN (NUM_SYN),
        .NUM_BLK (NUM_BLK)
    ) u_expand (
        .seed_i (seed_i),
        .pat_o  (seed_pat)
    );

    syn_block_rotate #(
        .BLK_W   (BLK_W),
        .NUM_BLK (NUM_BLK)
    ) u_rotate (
        .pat_i (st_q.pat),
        .pat_o (rot_pat)
    );

    always_comb begin
        req_steps = (steps_i > CNT_W'(MAX_STEP)) ? CNT_W'(MAX_STEP) : steps_i;
        st_d = st_q;
        if (load_i) begin
            st_d.pat  = seed_pat;
            st_d.left = '0;
        end else if (st_q.left != '0) begin
            st_d.pat  = rot_pat;
            st_d.left = st_q.left - CNT_W'(1);
        end else if (shift_i && (req_steps != '0)) begin
            st_d.pat  = rot_pat;
            st_d.left = req_steps - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign const_o = {{PAD_W{1'b0}}, st_q.pat};
    assign ready_o = (st_q.left == '0);

    // R3
    top_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        const_o[OUT_W-1:FIELD_W] == '0);

    // R4
    rotate_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && !ready_o) |=>
        (const_o[FIELD_W-1:0] == {$past(const_o[FIELD_W-BLK_W-1:0]),
                                  $past(const_o[FIELD_W-1:FIELD_W-BLK_W])}));

    // R4
    popcount_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> ($countones(const_o) == $countones($past(const_o))));

    // R7
    load_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> ready_o);

    // R8
    zero_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready_o && shift_i && !load_i && steps_i == '0) |=>
        ($stable(const_o) && ready_o));
endmodule

// File: tb/sim_syn_rc_rotator.sv
module sim_syn_rc_rotator;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load = 1'b0;
    logic [48:0]  seed = '0;
    logic         shift = 1'b0;
    logic [4:0]   steps = '0;
    logic [127:0] cst;
    logic         rdy;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    syn_rc_rotator u0 (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .load_i  (load),
        .seed_i  (seed),
        .shift_i (shift),
        .steps_i (steps),
        .const_o (cst),
        .ready_o (rdy)
    );

    // behavioural reference: eighteen 7-bit blocks and a pending count
    logic [6:0] m_blk [18];
    int         m_rem;

    function automatic logic [127:0] model_vec();
        logic [127:0] v = '0;
        for (int k = 0; k < 18; k++) v[k*7 +: 7] = m_blk[k];
        return v;
    endfunction

    task automatic m_rotate();
        logic [6:0] tmp [18];
        for (int k = 0; k < 18; k++) tmp[(k + 1) % 18] = m_blk[k];
        for (int k = 0; k < 18; k++) m_blk[k] = tmp[k];
    endtask

    always @(posedge clk) begin
        int n;
        if (!rst_n) begin
            for (int k = 0; k < 18; k++) m_blk[k] = '0;
            m_rem = 0;
        end else if (load) begin
            for (int k = 0; k < 18; k++) m_blk[k] = seed[(k % 7) * 7 +: 7];
            m_rem = 0;
        end else if (m_rem > 0) begin
            m_rotate();
            m_rem--;
        end else if (shift) begin
            n = (int'(steps) > 17) ? 17 : int'(steps);
            if (n > 0) begin
                m_rotate();
                m_rem = n - 1;
            end
        end
    end

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            check("R3 top bits", {126'd0, cst[127:126]}, '0);
            check("R5 model const", cst, model_vec());
            check("R6 model ready", {127'd0, rdy}, {127'd0, m_rem == 0});
        end
    end

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_load(logic [48:0] s);
        seed = s; load = 1'b1;
        cyc();
        load = 1'b0;
    endtask

    task automatic do_shift(int n);
        steps = 5'(n); shift = 1'b1;
        cyc();
        shift = 1'b0;
    endtask

    logic [48:0]  s_a, s_b;
    logic [127:0] snap;
    logic [127:0] expv;
    int           cnt;

    initial begin
        for (int j = 0; j < 7; j++) begin
            s_a[j*7 +: 7] = 7'(1 << j);
            s_b[j*7 +: 7] = 7'(1 << (6 - j));
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc();
        // R1
        check("R1 reset const", cst, '0);
        check("R1 reset ready", {127'd0, rdy}, 128'd1);

        // R2 expansion placement
        do_load(s_a);
        expv = '0;
        for (int k = 0; k < 18; k++) expv[k*7 +: 7] = 7'(1 << (k % 7));
        check("R2 one-hot expand", cst, expv);

        // R4 single step with wrap
        snap = cst;
        do_shift(1);
        expv = '0;
        expv[125:0] = {snap[118:0], snap[125:119]};
        check("R4 one step", cst, expv);
        check("R4 block17 to block0", {121'd0, cst[6:0]}, {121'd0, snap[125:119]});
        check("R6 n=1 ready", {127'd0, rdy}, 128'd1);

        // R5 and R6: five steps, ready low for four cycles
        do_shift(5);
        check("R6 busy", {127'd0, rdy}, 128'd0);
        cnt = 1;
        while (!rdy) begin cyc(); cnt++; end
        check("R5 five step length", 128'(cnt), 128'd5);

        // R6 request while busy ignored
        do_shift(10);
        snap = cst;
        do_shift(3);
        while (!rdy) cyc();
        check("R6 busy request ignored", {127'd0, rdy}, 128'd1);

        // R8 zero count
        snap = cst;
        do_shift(0);
        check("R8 zero count const", cst, snap);
        check("R8 zero count ready", {127'd0, rdy}, 128'd1);

        // R5 saturation: 31 acts as 17
        do_shift(31);
        cnt = 1;
        while (!rdy) begin cyc(); cnt++; end
        check("R5 saturated length", 128'(cnt), 128'd17);

        // R7 load during a sequence
        do_shift(12);
        cyc();
        steps = 5'd4; shift = 1'b1;
        do_load(s_b);
        shift = 1'b0;
        expv = '0;
        for (int k = 0; k < 18; k++) expv[k*7 +: 7] = 7'(1 << (6 - (k % 7)));
        check("R7 load wins", cst, expv);
        check("R7 ready after load", {127'd0, rdy}, 128'd1);
        cyc();
        check("R7 no leftover steps", cst, expv);

        // R9 period of eighteen
        snap = cst;
        do_shift(17);
        while (!rdy) cyc();
        do_shift(1);
        check("R9 full period", cst, snap);

        // R2 arbitrary seed copied unchanged
        do_load(49'h1_2345_6789_ABCD);
        expv = '0;
        for (int k = 0; k < 18; k++) expv[k*7 +: 7] = seed[(k % 7) * 7 +: 7];
        check("R2 arbitrary seed", cst, expv);
        do_shift(7);
        while (!rdy) cyc();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule